// File: doc/BRIEF.md
# I2S Serial Clock and Word-Select Generator

This block produces the serial bit clock and the word-select (left/right) clock of an I2S port. Both are produced as registered signals in the master clock domain. The block also produces two single-cycle strobes for a companion serializer. `launch_stb` marks the cycle in which a new data bit is launched. `frame_stb` marks the launch of the first bit of a left-channel word.

With `provider` set, the block is the clock source. It divides the master clock by 2 or 4 to form the bit clock, and counts 32, 64 or 128 bit clocks per stereo frame. A ratio that is reprogrammed while the port runs is held back until the current frame ends.

With `provider` clear, the bit clock and word select arrive from outside. The block resynchronizes them into the master clock domain and passes them through. It then derives the same strobes from their edges.

Polarity inputs choose the bit-clock sense and the word-select level of the left channel. In provider mode, a free-running option keeps the bit clock toggling through the unused tail of each channel slot. Without it, the bit clock is parked outside the first `ACTIVE_BITS` bits of each half frame.

Top module: `i2s_clkgen`

## Requirements
- R1: While `rst_n` is low, `bclk_o`, `ws_o`, `launch_stb` and `frame_stb` are all 0.
- R2: One clock edge after `enable` is sampled low, `bclk_o` equals `bclk_pol`, `ws_o` equals `ws_pol`, and both strobes are 0.
- R3: In provider mode, the bit clock period is 2 master clocks for `mdiv_sel`=0 and 4 for `mdiv_sel`=1. Each bit starts with its low half, before `bclk_pol` inverts the output.
- R4: In provider mode, a frame lasts 32 bits for `fdiv_sel`=0, 64 bits for 1, and 128 bits for 2 or 3. During the first half of the frame (left channel), `ws_o` equals `ws_pol`; during the second half, it is the opposite level.
- R5: `launch_stb` is a one-cycle pulse in the first master-clock cycle of each active bit. `frame_stb` is high only together with `launch_stb`, and only on bit 0 of a frame.
- R6: In provider mode with `free_run`=0, bits at slot index `ACTIVE_BITS` (16) or higher within either half frame hold `bclk_o` at its idle level (`bclk_pol`) and raise no `launch_stb`. `ws_o` keeps its normal timing.
- R7: In provider mode, a change of `mdiv_sel` or `fdiv_sel` while running takes effect only from the next frame boundary.
- R8: In provider mode, `frame_stb` first rises in the cycle after the second clock edge at which `enable` is sampled high.
- R9: In consumer mode, `bclk_o` and `ws_o` reproduce `ext_bclk` and `ext_ws` three clock edges after each input change.
- R10: In consumer mode, each falling edge of `ext_bclk ^ bclk_pol` gives exactly one `launch_stb` pulse, in the same cycle in which `bclk_o` first shows the new level.
- R11: In consumer mode, `frame_stb` accompanies a launch whose word-select level is the left level (`ws_pol`) when the previous launch saw the right level. After the block is enabled, a right half must pass before the first frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; when low, the clocks idle and the counters clear |
| provider | input | 1 | 1: the block generates the clocks; 0: it follows external clocks |
| mdiv_sel | input | 1 | Master-to-bit-clock ratio: 0 gives 2, 1 gives 4 |
| fdiv_sel | input | 2 | Bits per frame: 0 gives 32, 1 gives 64, 2 or 3 gives 128 |
| ws_pol | input | 1 | Word-select level that marks the left channel |
| bclk_pol | input | 1 | Inverts the bit clock sense |
| free_run | input | 1 | 1 keeps the bit clock running outside active slots |
| ext_bclk | input | 1 | External bit clock (consumer mode) |
| ext_ws | input | 1 | External word select (consumer mode) |
| bclk_o | output | 1 | Bit clock out |
| ws_o | output | 1 | Word select out |
| launch_stb | output | 1 | One-cycle pulse at each data launch |
| frame_stb | output | 1 | One-cycle pulse at the first launch of a left word |

## Verification
The assertions check on every cycle the relations that hold in all modes:
- the idle levels that follow a disable;
- a frame strobe always paired with a launch strobe;
- a frame strobe always at the left word-select level;
- launch pulses never on two consecutive cycles;
- in provider mode, a word-select transition always coinciding with a launch.

The actual division ratios, the deferral of a ratio change to the frame boundary, the gated slot tail, start-up latency and the consumer-path latency all depend on counted history. These are shown only by the bench's scenarios, which compare every cycle against a behavioural reference model and count the cycles and pulses between strobes.

// File: rtl/i2s_cg_pkg.sv
package i2s_cg_pkg;
  localparam int MAX_MRATIO = 4;
  localparam int MAX_FRATIO = 128;
  localparam int MC_W = $clog2(MAX_MRATIO);
  localparam int BC_W = $clog2(MAX_FRATIO);
  localparam int MR_W = MC_W + 1;
  localparam int FR_W = BC_W + 1;

  typedef struct packed {
    logic bclk;
    logic ws;
    logic launch;
    logic frame;
  } cg_pins_t;

  function automatic logic [MR_W-1:0] mratio_of(input logic sel);
    return sel ? MR_W'(4) : MR_W'(2);
  endfunction

  function automatic logic [FR_W-1:0] fratio_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return FR_W'(32);
      2'd1:    return FR_W'(64);
      default: return FR_W'(128);
    endcase
  endfunction

  function automatic cg_pins_t idle_pins(input logic bpol, input logic wpol);
    cg_pins_t p;
    p.bclk   = bpol;
    p.ws     = wpol;
    p.launch = 1'b0;
    p.frame  = 1'b0;
    return p;
  endfunction
endpackage

// File: rtl/i2s_cg_divider.sv
module i2s_cg_divider
  import i2s_cg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            mdiv_sel,
  input  logic [1:0]      fdiv_sel,
  output logic            run,
  output logic [MC_W-1:0] mcnt,
  output logic [BC_W-1:0] bcnt,
  output logic [MR_W-1:0] mratio,
  output logic [FR_W-1:0] fratio
);
  logic       msel_q;
  logic [1:0] fsel_q;
  logic       bit_end;
  logic       frame_end;

  // ratios in use come from the latched selects, refreshed only at frame edges
  assign mratio    = mratio_of(msel_q);
  assign fratio    = fratio_of(fsel_q);
  assign bit_end   = ({1'b0, mcnt} == (mratio - 1'b1));
  assign frame_end = bit_end && ({1'b0, bcnt} == (fratio - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      mcnt   <= '0;
      bcnt   <= '0;
      msel_q <= 1'b0;
      fsel_q <= '0;
    end else if (!go || !run) begin
      run    <= go;
      mcnt   <= '0;
      bcnt   <= '0;
      msel_q <= mdiv_sel;
      fsel_q <= fdiv_sel;
    end else if (frame_end) begin
      mcnt   <= '0;
      bcnt   <= '0;
      msel_q <= mdiv_sel;
      fsel_q <= fdiv_sel;
    end else if (bit_end) begin
      mcnt <= '0;
      bcnt <= bcnt + 1'b1;
    end else begin
      mcnt <= mcnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_cg_decode.sv
module i2s_cg_decode
  import i2s_cg_pkg::*;
#(
  parameter int ACTIVE_BITS = 16
) (
  input  logic            run,
  input  logic [MC_W-1:0] mcnt,
  input  logic [BC_W-1:0] bcnt,
  input  logic [MR_W-1:0] mratio,
  input  logic [FR_W-1:0] fratio,
  input  logic            free_run,
  input  logic            bclk_pol,
  input  logic            ws_pol,
  output cg_pins_t        pins
);
  logic [FR_W-1:0] half;
  logic            left;
  logic [BC_W-1:0] slot;
  logic            active;
  logic            hi_phase;

  always_comb begin
    half     = fratio >> 1;
    left     = ({1'b0, bcnt} < half);
    slot     = left ? bcnt : (bcnt - half[BC_W-1:0]);
    active   = free_run || (int'(32'(slot)) < ACTIVE_BITS);
    hi_phase = ({1'b0, mcnt} >= (mratio >> 1));
    if (!run) begin
      pins = idle_pins(bclk_pol, ws_pol);
    end else begin
      pins.bclk   = (hi_phase && active) ^ bclk_pol;
      pins.ws     = left ? ws_pol : ~ws_pol;
      pins.launch = active && (mcnt == '0);
      pins.frame  = (mcnt == '0) && (bcnt == '0);
    end
  end
endmodule

// File: rtl/i2s_cg_follower.sv
module i2s_cg_follower
  import i2s_cg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     live,
  input  logic     ext_bclk,
  input  logic     ext_ws,
  input  logic     bclk_pol,
  input  logic     ws_pol,
  output cg_pins_t pins
);
  logic [STAGES-1:0] bsync;
  logic [STAGES-1:0] wsync;
  logic              bprev;
  logic              last_left;
  logic              fall;
  logic              ws_left;

  assign fall    = (bprev ^ bclk_pol) && !(bsync[STAGES-1] ^ bclk_pol);
  assign ws_left = (wsync[STAGES-1] == ws_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync     <= '0;
      wsync     <= '0;
      bprev     <= 1'b0;
      last_left <= 1'b1;
    end else begin
      bsync <= {bsync[STAGES-2:0], ext_bclk};
      wsync <= {wsync[STAGES-2:0], ext_ws};
      bprev <= bsync[STAGES-1];
      if (!live)     last_left <= 1'b1;
      else if (fall) last_left <= ws_left;
    end
  end

  always_comb begin
    pins.bclk   = bsync[STAGES-1];
    pins.ws     = wsync[STAGES-1];
    pins.launch = fall;
    pins.frame  = fall && ws_left && !last_left;
  end
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_cg_pkg::*;
#(
  parameter int ACTIVE_BITS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       provider,
  input  logic       mdiv_sel,
  input  logic [1:0] fdiv_sel,
  input  logic       ws_pol,
  input  logic       bclk_pol,
  input  logic       free_run,
  input  logic       ext_bclk,
  input  logic       ext_ws,
  output logic       bclk_o,
  output logic       ws_o,
  output logic       launch_stb,
  output logic       frame_stb
);
  logic            gen_go;
  logic            fol_live;
  logic            run;
  logic [MC_W-1:0] mcnt;
  logic [BC_W-1:0] bcnt;
  logic [MR_W-1:0] mratio;
  logic [FR_W-1:0] fratio;
  cg_pins_t        gen_pins;
  cg_pins_t        fol_pins;
  cg_pins_t        out_q;

  assign gen_go   = enable && provider;
  assign fol_live = enable && !provider;

  i2s_cg_divider u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (gen_go),
    .mdiv_sel (mdiv_sel),
    .fdiv_sel (fdiv_sel),
    .run      (run),
    .mcnt     (mcnt),
    .bcnt     (bcnt),
    .mratio   (mratio),
    .fratio   (fratio)
  );

  i2s_cg_decode #(.ACTIVE_BITS(ACTIVE_BITS)) u_dec (
    .run      (run),
    .mcnt     (mcnt),
    .bcnt     (bcnt),
    .mratio   (mratio),
    .fratio   (fratio),
    .free_run (free_run),
    .bclk_pol (bclk_pol),
    .ws_pol   (ws_pol),
    .pins     (gen_pins)
  );

  i2s_cg_follower #(.STAGES(SYNC_STAGES)) u_fol (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (fol_live),
    .ext_bclk (ext_bclk),
    .ext_ws   (ext_ws),
    .bclk_pol (bclk_pol),
    .ws_pol   (ws_pol),
    .pins     (fol_pins)
  );

  // registered pins: the clocks leave the block from flops only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= '0;
    else if (gen_go)   out_q <= gen_pins;
    else if (fol_live) out_q <= fol_pins;
    else               out_q <= idle_pins(bclk_pol, ws_pol);
  end

  assign bclk_o     = out_q.bclk;
  assign ws_o       = out_q.ws;
  assign launch_stb = out_q.launch;
  assign frame_stb  = out_q.frame;
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic provider,
  input logic ws_pol,
  input logic bclk_pol,
  input logic bclk_o,
  input logic ws_o,
  input logic launch_stb,
  input logic frame_stb
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rst_n && !$past(rst_n)) |-> (!bclk_o && !ws_o && !launch_stb && !frame_stb));

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(enable)) |->
      (bclk_o == $past(bclk_pol) && ws_o == $past(ws_pol) && !launch_stb && !frame_stb));

  assert_frame_has_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> launch_stb);

  assert_launch_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |=> (!launch_stb || ($past(provider, 2) != $past(provider))));

  assert_frame_left_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (ws_o == $past(ws_pol)));

  assert_ws_moves_on_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && $past(provider) && $past(enable, 2) && $past(provider, 2) &&
     ($past(ws_pol) == $past(ws_pol, 2)) && (ws_o != $past(ws_o))) |-> launch_stb);
endmodule

bind i2s_clkgen i2s_clkgen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .provider   (provider),
  .ws_pol     (ws_pol),
  .bclk_pol   (bclk_pol),
  .bclk_o     (bclk_o),
  .ws_o       (ws_o),
  .launch_stb (launch_stb),
  .frame_stb  (frame_stb)
);

// File: tb/i2s_clkgen_test.sv
`timescale 1ns/1ps
module i2s_clkgen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, provider = 1'b0, mdiv_sel = 1'b0, ws_pol = 1'b0;
  logic bclk_pol = 1'b0, free_run = 1'b0, ext_bclk = 1'b0, ext_ws = 1'b0;
  logic [1:0] fdiv_sel = 2'd0;
  logic bclk_o, ws_o, launch_stb, frame_stb;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  string scen = "R1";

  always #5 clk = ~clk;

  i2s_clkgen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .provider(provider),
    .mdiv_sel(mdiv_sel), .fdiv_sel(fdiv_sel), .ws_pol(ws_pol),
    .bclk_pol(bclk_pol), .free_run(free_run), .ext_bclk(ext_bclk),
    .ext_ws(ext_ws), .bclk_o(bclk_o), .ws_o(ws_o),
    .launch_stb(launch_stb), .frame_stb(frame_stb)
  );

  // behavioural reference: one tick counter per frame plus input history
  bit e_b, e_w, e_l, e_f;
  bit mrun, cl, hb1, hb2, hb3, hw1, hw2;
  int tick, mm, mf;

  always @(posedge clk) begin
    if (!rst_n) begin
      {e_b, e_w, e_l, e_f} = 4'b0;
      mrun = 0; cl = 1; {hb1, hb2, hb3, hw1, hw2} = 5'b0; tick = 0;
    end else begin
      bit cfall, cleft, act, lft;
      int bp, sub, slot;
      cfall = (hb3 ^ bclk_pol) && !(hb2 ^ bclk_pol);
      cleft = (hw2 == ws_pol);
      if (enable && provider) begin
        if (!mrun) begin
          e_b = bclk_pol; e_w = ws_pol; e_l = 0; e_f = 0;
          mrun = 1; tick = 0;
          mm = mdiv_sel ? 4 : 2;
          mf = (fdiv_sel == 0) ? 32 : (fdiv_sel == 1) ? 64 : 128;
        end else begin
          bp = tick / mm; sub = tick % mm;
          lft = bp < mf / 2;
          slot = lft ? bp : bp - mf / 2;
          act = free_run || slot < 16;
          e_b = ((sub >= mm / 2) && act) ^ bclk_pol;
          e_w = lft ? ws_pol : !ws_pol;
          e_l = act && sub == 0;
          e_f = (tick == 0);
          tick++;
          if (tick == mm * mf) begin
            tick = 0;
            mm = mdiv_sel ? 4 : 2;
            mf = (fdiv_sel == 0) ? 32 : (fdiv_sel == 1) ? 64 : 128;
          end
        end
      end else begin
        mrun = 0;
        if (enable) begin
          e_b = hb2; e_w = hw2; e_l = cfall; e_f = cfall && cleft && !cl;
        end else begin
          e_b = bclk_pol; e_w = ws_pol; e_l = 0; e_f = 0;
        end
      end
      if (!(enable && !provider)) cl = 1;
      else if (cfall) cl = cleft;
      hb3 = hb2; hb2 = hb1; hb1 = ext_bclk; hw2 = hw1; hw1 = ext_ws;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if ({bclk_o, ws_o, launch_stb, frame_stb} !== {e_b, e_w, e_l, e_f}) begin
        n_bad++;
        $display("FAIL %s model compare at cycle %0d: got %b expected %b", scen, cyc,
                 {bclk_o, ws_o, launch_stb, frame_stb}, {e_b, e_w, e_l, e_f});
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic frame_gap(output int cycles, output int launches);
    do @(negedge clk); while (!frame_stb);
    cycles = 0; launches = 1;
    do begin
      @(negedge clk); cycles++;
      if (launch_stb && !frame_stb) launches++;
    end while (!frame_stb);
  endtask

  // consumer pulse counters
  bit cnt_on = 0;
  int cnt_l = 0, cnt_f = 0;
  always @(negedge clk) if (cnt_on) begin
    if (launch_stb) cnt_l++;
    if (frame_stb) cnt_f++;
  end

  task automatic drive_ext(input int frames, input bit lvl);
    for (int f = 0; f < frames; f++)
      for (int b = 0; b < 32; b++) begin
        @(negedge clk); ext_ws = (b < 16) ? lvl : !lvl; ext_bclk = 1'b0;
        repeat (3) @(negedge clk); ext_bclk = 1'b1;
        repeat (2) @(negedge clk);
      end
  endtask

  task automatic stop_run;
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c, l;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {bclk_o, ws_o, launch_stb, frame_stb}, 0);
    rst_n = 1'b1;

    scen = "R2";
    bclk_pol = 1; ws_pol = 1;
    repeat (3) @(negedge clk);
    chk("R2 idle bclk", bclk_o, 1);
    chk("R2 idle ws", ws_o, 1);
    chk("R2 idle strobes", launch_stb + frame_stb, 0);

    scen = "R8";
    bclk_pol = 0; ws_pol = 0; provider = 1; mdiv_sel = 0; fdiv_sel = 0; free_run = 1;
    @(negedge clk); enable = 1;
    @(negedge clk); chk("R8 no frame after first edge", frame_stb, 0);
    @(negedge clk); chk("R8 frame after second edge", frame_stb, 1);
    chk("R5 launch with frame", launch_stb, 1);

    scen = "R3";
    do @(negedge clk); while (!launch_stb);
    c = 0;
    do begin @(negedge clk); c++; end while (!launch_stb);
    chk("R3 bit period ratio 2", c, 2);

    scen = "R4";
    frame_gap(c, l);
    chk("R4 frame 32 bits x2", c, 64);
    chk("R5 launches per frame", l, 32);

    scen = "R7";
    do @(negedge clk); while (!frame_stb);
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 5) fdiv_sel = 2'd1;
    end while (!frame_stb);
    chk("R7 old ratio kept this frame", c, 64);
    frame_gap(c, l);
    chk("R7 new ratio next frame", c, 128);
    stop_run;

    scen = "R6";
    mdiv_sel = 1; fdiv_sel = 1; free_run = 0; ws_pol = 1; bclk_pol = 1;
    @(negedge clk); enable = 1;
    frame_gap(c, l);
    chk("R6 gated frame length", c, 256);
    chk("R6 launches only in active slots", l, 32);
    do @(negedge clk); while (!launch_stb);
    c = 0;
    do begin @(negedge clk); c++; end while (!launch_stb);
    chk("R3 bit period ratio 4", c, 4);
    stop_run;

    scen = "R4";
    mdiv_sel = 0; fdiv_sel = 3; free_run = 1; ws_pol = 0; bclk_pol = 0;
    @(negedge clk); enable = 1;
    frame_gap(c, l);
    chk("R4 code 3 gives 128 bits", c, 256);
    chk("R4 launches in 128-bit frame", l, 128);
    stop_run;

    scen = "R10";
    provider = 0; mdiv_sel = 1; fdiv_sel = 2;
    @(negedge clk); enable = 1;
    cnt_l = 0; cnt_f = 0; cnt_on = 1;
    drive_ext(4, 1'b0);
    repeat (6) @(negedge clk);
    cnt_on = 0;
    chk("R10 one launch per falling edge", cnt_l, 127);
    chk("R11 frames after a right half", cnt_f, 3);

    scen = "R9";
    @(negedge clk); ext_ws = ~ext_ws;
    @(negedge clk); @(negedge clk);
    chk("R9 ws not yet through", ws_o, !ext_ws);
    @(negedge clk);
    chk("R9 ws through after three edges", ws_o, ext_ws);
    stop_run;

    scen = "R11";
    bclk_pol = 1; ws_pol = 1;
    @(negedge clk); enable = 1;
    cnt_l = 0; cnt_f = 0; cnt_on = 1;
    drive_ext(2, 1'b1);
    repeat (6) @(negedge clk);
    cnt_on = 0;
    chk("R10 inverted launches", cnt_l, 64);
    chk("R11 inverted frame count", cnt_f, 1);
    stop_run;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule